// File: doc/BRIEF.md
# Multi-Core Exclusive Access Monitor

This block sits between several cores and a small shared word store and gives each core the load-exclusive / store-exclusive pair used to build locks. Each core holds one reservation: a flag that is either Open or Exclusive, plus the full word address it was armed on. A load-exclusive arms the reservation. A store-exclusive commits only if the reservation is still armed on that same address. Any write by a core to a watched word knocks out the reservation of every other core watching that word.

Each knocked-out reservation also raises a one-cycle wake pulse to the core that lost it, so the monitor doubles as a doorbell for cores sleeping on a lock. A core that parks after seeing the lock held is woken by the owner's plain release store. No separate signalling is needed.

All requests presented in one clock cycle are applied in a fixed order, lowest core index first. A later request sees the writes and reservation losses of every earlier one. Responses and wake pulses are registered and appear one cycle after the request.

Top module: `excl_monitor_hub`

## Requirements
- R1: A valid load-exclusive (kind code 2'b01) returns the addressed word on `rsp_rdata` one cycle later. It arms the issuing core's reservation as Exclusive on the full word address.
- R2: A valid store-exclusive (kind code 2'b11) writes the word only if the issuing core is Exclusive on that address. Its status is 0 on success. On failure the status is 1 and the word is unchanged.
- R3: A store-exclusive to an address other than the one its core is armed on fails with status 1 and writes nothing.
- R4: A committed write (plain store, kind code 2'b10, or a successful store-exclusive) sets to Open every other core's reservation armed on that address. Reservations on other addresses are left armed.
- R5: A core whose Exclusive reservation is knocked out by another core's write sees `wake_evt` high for exactly one cycle, in the cycle its response appears.
- R6: A store-exclusive, whether it succeeds or fails, returns the issuing core's reservation to Open and raises no wake pulse for that core.
- R7: Same-cycle requests are applied in order of core index, lowest first. A later load returns a word written earlier in that cycle. A later store-exclusive to that word fails. A reservation armed earlier in the cycle and then hit by a later write in the same cycle is lost, with a wake pulse. A reservation armed after an earlier write in the same cycle is kept.
- R8: After reset every reservation is Open, every word reads zero, and `rsp_valid` and `wake_evt` are low.
- R9: A plain store of zero to a lock word wakes every core armed on it, with one pulse each.
- R10: `rsp_valid` follows `req_valid` by one cycle. Requests that are not store-exclusive report status 0. Plain loads (kind code 2'b00) return the word. Stores return zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | NUM_CORES | Request present, one bit per core |
| req_kind | input | 2*NUM_CORES | Per-core kind: 00 load, 01 load-exclusive, 10 store, 11 store-exclusive |
| req_addr | input | NUM_CORES*ADDR_W | Per-core word address |
| req_wdata | input | NUM_CORES*DATA_W | Per-core store data |
| rsp_valid | output | NUM_CORES | Response present, one cycle after request |
| rsp_status | output | NUM_CORES | Store-exclusive failure flag (1 = failed) |
| rsp_rdata | output | NUM_CORES*DATA_W | Per-core load data |
| wake_evt | output | NUM_CORES | One-cycle pulse when that core's reservation is lost to another core |

## Verification
The bench builds the block with four cores, a 4-bit word address (16 words) and 16-bit data. Four cores allow three-way and four-way contention in a single cycle. With that, a lower-index store can be shown overtaking a higher-index load-exclusive, and the reverse ordering can be shown losing a fresh reservation within the cycle it was made. Sixteen words leave room for a lock word, its neighbours and untouched addresses, so the bench can show that knock-outs stay on the address that was written. The 16-bit data width keeps distinct marker values in every word, so forwarded data and failed writes can be told apart.

// File: rtl/excl_pkg.sv
package excl_pkg;
   typedef enum logic [1:0] {
      K_LOAD  = 2'b00,
      K_LDX   = 2'b01,
      K_STORE = 2'b10,
      K_STX   = 2'b11
   } req_kind_e;
endpackage

// File: rtl/excl_resv_slot.sv
module excl_resv_slot #(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nxt_excl,
   input  logic [ADDR_W-1:0] nxt_tag,
   output logic              excl,
   output logic [ADDR_W-1:0] tag
);
   if (ADDR_W < 1) begin : g_bad_width
      $error("excl_resv_slot: ADDR_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         excl <= 1'b0;
         tag  <= '0;
      end else begin
         excl <= nxt_excl;
         tag  <= nxt_tag;
      end
   end
endmodule

// File: rtl/excl_word_file.sv
module excl_word_file #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32,
   parameter int PORTS  = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [PORTS-1:0]             wr_en,
   input  logic [PORTS-1:0][ADDR_W-1:0] wr_addr,
   input  logic [PORTS-1:0][DATA_W-1:0] wr_data,
   input  logic [PORTS-1:0][ADDR_W-1:0] rd_addr,
   output logic [PORTS-1:0][DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W > 10) begin : g_bad_depth
      $error("excl_word_file: ADDR_W too large for a register file");
   end

   logic [DEPTH-1:0][DATA_W-1:0] words;

   // higher port index is applied last and wins on a shared address
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         words <= '0;
      end else begin
         for (int p = 0; p < PORTS; p++) begin
            if (wr_en[p]) words[wr_addr[p]] <= wr_data[p];
         end
      end
   end

   for (genvar p = 0; p < PORTS; p++) begin : g_rd
      assign rd_data[p] = words[rd_addr[p]];
   end
endmodule

// File: rtl/excl_monitor_hub.sv
module excl_monitor_hub
   import excl_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_CORES-1:0]          req_valid,
   input  logic [2*NUM_CORES-1:0]        req_kind,
   input  logic [NUM_CORES*ADDR_W-1:0]   req_addr,
   input  logic [NUM_CORES*DATA_W-1:0]   req_wdata,
   output logic [NUM_CORES-1:0]          rsp_valid,
   output logic [NUM_CORES-1:0]          rsp_status,
   output logic [NUM_CORES*DATA_W-1:0]   rsp_rdata,
   output logic [NUM_CORES-1:0]          wake_evt
);
   localparam int N = NUM_CORES;

   if (NUM_CORES < 1 || DATA_W < 1 || ADDR_W < 1) begin : g_bad_param
      $error("excl_monitor_hub: NUM_CORES, ADDR_W and DATA_W must be positive");
   end

   req_kind_e                   kind   [N];
   logic [N-1:0][ADDR_W-1:0]    addr;
   logic [N-1:0][DATA_W-1:0]    wdata;
   logic [N-1:0]                resv_excl;
   logic [N-1:0][ADDR_W-1:0]    resv_tag;
   logic [N-1:0][DATA_W-1:0]    mem_rd;
   logic [N-1:0]                commit;
   logic [N-1:0]                succ;
   logic [N-1:0]                lost;
   logic [N-1:0]                excl_nxt;
   logic [N-1:0][ADDR_W-1:0]    tag_nxt;
   logic [N-1:0][DATA_W-1:0]    rd_fwd;

   for (genvar i = 0; i < N; i++) begin : g_core
      assign kind[i]  = req_kind_e'(req_kind[2*i +: 2]);
      assign addr[i]  = req_addr[i*ADDR_W +: ADDR_W];
      assign wdata[i] = req_wdata[i*DATA_W +: DATA_W];

      excl_resv_slot #(.ADDR_W(ADDR_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .nxt_excl (excl_nxt[i]),
         .nxt_tag  (tag_nxt[i]),
         .excl     (resv_excl[i]),
         .tag      (resv_tag[i])
      );
   end

   excl_word_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORTS(N)) u_words (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (commit),
      .wr_addr (addr),
      .wr_data (wdata),
      .rd_addr (addr),
      .rd_data (mem_rd)
   );

   // requests are applied one after another in core-index order
   always_comb begin : p_serial
      logic [N-1:0]             cm, sc, xm, lp, hit;
      logic [N-1:0][ADDR_W-1:0] tm;
      logic [N-1:0][DATA_W-1:0] rd;
      cm = '0; sc = '0; xm = '0; lp = '0; hit = '0; tm = '0; rd = '0;
      for (int i = 0; i < N; i++) begin
         for (int j = 0; j < i; j++) begin
            if (cm[j] && addr[j] == resv_tag[i]) hit[i] = 1'b1;
         end
         lp[i] = resv_excl[i] && hit[i];
         xm[i] = resv_excl[i] && !hit[i];
         tm[i] = resv_tag[i];
         rd[i] = mem_rd[i];
         for (int j = 0; j < i; j++) begin
            if (cm[j] && addr[j] == addr[i]) rd[i] = wdata[j];
         end
         sc[i] = req_valid[i] && kind[i] == K_STX && xm[i] && resv_tag[i] == addr[i];
         cm[i] = req_valid[i] && (kind[i] == K_STORE || sc[i]);
         if (req_valid[i] && kind[i] == K_LDX) begin
            xm[i] = 1'b1;
            tm[i] = addr[i];
         end else if (req_valid[i] && kind[i] == K_STX) begin
            xm[i] = 1'b0;
         end
      end
      // writes later in the order hit reservations as they stand after each core's own step
      for (int i = 0; i < N; i++) begin
         for (int j = i + 1; j < N; j++) begin
            if (xm[i] && cm[j] && addr[j] == tm[i]) begin
               xm[i] = 1'b0;
               lp[i] = 1'b1;
            end
         end
      end
      commit   = cm;
      succ     = sc;
      lost     = lp;
      excl_nxt = xm;
      tag_nxt  = tm;
      rd_fwd   = rd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= '0;
         rsp_status <= '0;
         rsp_rdata  <= '0;
         wake_evt   <= '0;
      end else begin
         rsp_valid <= req_valid;
         wake_evt  <= lost;
         for (int i = 0; i < N; i++) begin
            rsp_status[i] <= req_valid[i] && kind[i] == K_STX && !succ[i];
            rsp_rdata[i*DATA_W +: DATA_W] <=
               (req_valid[i] && (kind[i] == K_LOAD || kind[i] == K_LDX)) ? rd_fwd[i] : '0;
         end
      end
   end
endmodule

// File: rtl/excl_monitor_hub_chk.sv
module excl_monitor_hub_chk
   import excl_pkg::*;
#(
   parameter int NUM_CORES = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_CORES-1:0]   req_valid,
   input logic [2*NUM_CORES-1:0] req_kind,
   input logic [NUM_CORES-1:0]   rsp_valid,
   input logic [NUM_CORES-1:0]   rsp_status,
   input logic [NUM_CORES-1:0]   wake_evt,
   input logic [NUM_CORES-1:0]   resv_excl
);
   logic [NUM_CORES-1:0] is_ldx, is_stx, is_wr, other_wr;

   for (genvar i = 0; i < NUM_CORES; i++) begin : g_dec
      assign is_ldx[i] = req_valid[i] && req_kind[2*i +: 2] == K_LDX;
      assign is_stx[i] = req_valid[i] && req_kind[2*i +: 2] == K_STX;
      assign is_wr[i]  = req_valid[i] && req_kind[2*i +: 2] inside {K_STORE, K_STX};
      assign other_wr[i] = |(is_wr & ~(NUM_CORES'(1) << i));
   end

   for (genvar i = 0; i < NUM_CORES; i++) begin : g_prop
      // R1: a load-exclusive leaves the core armed unless it was knocked out (and woken)
      a_r1_ldx_arms: assert property (@(posedge clk) disable iff (!rst_n)
         is_ldx[i] |=> (resv_excl[i] || wake_evt[i]));
      // R2: an unarmed store-exclusive always reports failure
      a_r2_unarmed_fails: assert property (@(posedge clk) disable iff (!rst_n)
         (is_stx[i] && !resv_excl[i]) |=> rsp_status[i]);
      // R6: any store-exclusive leaves its core Open
      a_r6_stx_opens: assert property (@(posedge clk) disable iff (!rst_n)
         is_stx[i] |=> !resv_excl[i]);
      // R5: a wake pulse needs another core's write and a reservation to lose
      a_r5_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
         wake_evt[i] |-> ($past(other_wr[i]) && ($past(resv_excl[i]) || $past(is_ldx[i]))));
      // R10: response follows request by one cycle
      a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid[i] |=> rsp_valid[i]);
      // R10: only store-exclusive can report failure
      a_r10_status_only_stx: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid[i] && !is_stx[i]) |=> !rsp_status[i]);
   end
endmodule

bind excl_monitor_hub excl_monitor_hub_chk #(.NUM_CORES(NUM_CORES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_kind   (req_kind),
   .rsp_valid  (rsp_valid),
   .rsp_status (rsp_status),
   .wake_evt   (wake_evt),
   .resv_excl  (resv_excl)
);

// File: tb/excl_monitor_hub_tb.sv
module excl_monitor_hub_tb;
   localparam int N  = 4;
   localparam int AW = 4;
   localparam int DW = 16;
   localparam logic [1:0] LD = 2'b00, LDX = 2'b01, ST = 2'b10, STX = 2'b11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [N-1:0]      v;
   logic [1:0]        k [N];
   logic [AW-1:0]     a [N];
   logic [DW-1:0]     d [N];
   logic [N-1:0]      req_valid;
   logic [2*N-1:0]    req_kind;
   logic [N*AW-1:0]   req_addr;
   logic [N*DW-1:0]   req_wdata;
   logic [N-1:0]      rsp_valid, rsp_status, wake_evt;
   logic [N*DW-1:0]   rsp_rdata;

   always_comb begin
      req_valid = v;
      for (int i = 0; i < N; i++) begin
         req_kind[2*i +: 2]   = k[i];
         req_addr[i*AW +: AW] = a[i];
         req_wdata[i*DW +: DW] = d[i];
      end
   end

   excl_monitor_hub #(.NUM_CORES(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_status(rsp_status), .rsp_rdata(rsp_rdata), .wake_evt(wake_evt)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] rdat(input int c);
      return rsp_rdata[c*DW +: DW];
   endfunction

   task automatic clr();
      v = '0;
      for (int i = 0; i < N; i++) begin k[i] = LD; a[i] = '0; d[i] = '0; end
   endtask

   task automatic put(input int c, input logic [1:0] kk, input int ad, input int dd);
      v[c] = 1'b1; k[c] = kk; a[c] = AW'(ad); d[c] = DW'(dd);
   endtask

   // pass one rising edge and stop on the falling edge after it
   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R8 rsp_valid after reset", 32'(rsp_valid), 0);
      chk("R8 wake after reset", 32'(wake_evt), 0);
      clr(); put(0, LD, 5, 0); put(3, LD, 15, 0); cyc();
      chk("R8 word 5 zero", 32'(rdat(0)), 0);
      chk("R8 word 15 zero", 32'(rdat(3)), 0);
      chk("R10 rsp_valid follows", 32'(rsp_valid), 32'b1001);
      clr(); cyc();
      chk("R10 rsp_valid drops", 32'(rsp_valid), 0);
   endtask

   task automatic t_basic();
      clr(); put(1, ST, 3, 16'h1234); cyc();
      chk("R10 store status", 32'(rsp_status[1]), 0);
      chk("R10 store data zero", 32'(rdat(1)), 0);
      clr(); put(1, LDX, 3, 0); cyc();
      chk("R1 ldx data", 32'(rdat(1)), 16'h1234);
      chk("R1 ldx no wake", 32'(wake_evt), 0);
      clr(); put(1, STX, 3, 16'h5555); cyc();
      chk("R2 stx success status", 32'(rsp_status[1]), 0);
      clr(); put(1, LD, 3, 0); cyc();
      chk("R2 stx wrote", 32'(rdat(1)), 16'h5555);
      clr(); put(1, STX, 3, 16'h6666); cyc();
      chk("R6 second stx fails", 32'(rsp_status[1]), 1);
      clr(); put(1, LD, 3, 0); cyc();
      chk("R2 failed stx no write", 32'(rdat(1)), 16'h5555);
   endtask

   task automatic t_mismatch();
      clr(); put(2, LDX, 7, 0); cyc();
      clr(); put(2, STX, 8, 9); cyc();
      chk("R3 other-address stx fails", 32'(rsp_status[2]), 1);
      chk("R6 no self wake", 32'(wake_evt), 0);
      clr(); put(2, LD, 8, 0); cyc();
      chk("R3 word 8 untouched", 32'(rdat(2)), 0);
   endtask

   task automatic t_steal();
      clr(); put(0, LDX, 2, 0); put(3, LDX, 2, 0); put(1, LDX, 9, 0); cyc();
      clr(); put(2, ST, 2, 7); cyc();
      chk("R5 wake on lost reservations", 32'(wake_evt), 32'b1001);
      clr(); cyc();
      chk("R5 wake lasts one cycle", 32'(wake_evt), 0);
      clr(); put(0, STX, 2, 1); cyc();
      chk("R4 core0 reservation gone", 32'(rsp_status[0]), 1);
      clr(); put(3, STX, 2, 1); cyc();
      chk("R4 core3 reservation gone", 32'(rsp_status[3]), 1);
      clr(); put(1, STX, 9, 16'h0099); cyc();
      chk("R4 other address kept", 32'(rsp_status[1]), 0);
      clr(); put(0, LD, 2, 0); put(2, LD, 9, 0); cyc();
      chk("R2 failed stx left word", 32'(rdat(0)), 7);
      chk("R2 word 9 written", 32'(rdat(2)), 16'h0099);
   endtask

   task automatic t_self();
      clr(); put(0, LDX, 4, 0); cyc();
      clr(); put(0, STX, 4, 16'h0044); cyc();
      chk("R6 own stx succeeds", 32'(rsp_status[0]), 0);
      chk("R6 own stx raises no wake", 32'(wake_evt), 0);
      clr(); put(0, STX, 4, 16'h0045); cyc();
      chk("R6 monitor back to Open", 32'(rsp_status[0]), 1);
   endtask

   task automatic t_prio();
      clr(); put(1, LDX, 6, 0); put(2, LDX, 6, 0); cyc();
      chk("R7 dual ldx no wake", 32'(wake_evt), 0);
      clr(); put(1, STX, 6, 16'h000A); put(2, STX, 6, 16'h000B); cyc();
      chk("R7 lower index wins", 32'(rsp_status[1]), 0);
      chk("R7 higher index fails", 32'(rsp_status[2]), 1);
      chk("R7 loser woken", 32'(wake_evt), 32'b0100);
      clr(); put(0, ST, 11, 16'h0077); put(1, LD, 11, 0); put(2, LDX, 12, 0); put(3, ST, 12, 5); cyc();
      chk("R7 forwarded load", 32'(rdat(1)), 16'h0077);
      chk("R7 ldx before later store reads old", 32'(rdat(2)), 0);
      chk("R7 fresh reservation lost in cycle", 32'(wake_evt), 32'b0100);
      clr(); put(0, ST, 13, 16'h0021); put(3, LDX, 13, 0); cyc();
      chk("R7 ldx after earlier store", 32'(rdat(3)), 16'h0021);
      chk("R7 arm after store no wake", 32'(wake_evt), 0);
      clr(); put(2, STX, 12, 9); put(3, STX, 13, 16'h0022); cyc();
      chk("R7 lost-in-cycle stx fails", 32'(rsp_status[2]), 1);
      chk("R7 kept reservation stx ok", 32'(rsp_status[3]), 0);
      clr(); put(0, LD, 12, 0); put(1, LD, 13, 0); put(2, LD, 6, 0); cyc();
      chk("R7 word 12", 32'(rdat(0)), 5);
      chk("R7 word 13", 32'(rdat(1)), 16'h0022);
      chk("R7 word 6", 32'(rdat(2)), 16'h000A);
   endtask

   task automatic t_release();
      clr(); put(0, LDX, 1, 0); cyc();
      chk("R1 lock free", 32'(rdat(0)), 0);
      clr(); put(0, STX, 1, 1); cyc();
      chk("R2 lock taken", 32'(rsp_status[0]), 0);
      clr(); put(1, LDX, 1, 0); put(2, LDX, 1, 0); put(3, LDX, 1, 0); cyc();
      chk("R1 waiters see held", 32'({rdat(1), rdat(2)}), 32'h00010001);
      clr(); put(0, ST, 1, 0); cyc();
      chk("R9 release wakes all waiters", 32'(wake_evt), 32'b1110);
      clr(); put(1, LDX, 1, 0); put(2, LDX, 1, 0); cyc();
      chk("R9 retry reads free", 32'({rdat(1), rdat(2)}), 0);
      clr(); put(2, STX, 1, 2); put(1, STX, 1, 1); cyc();
      chk("R7 race lower index takes lock", 32'({rsp_status[2], rsp_status[1]}), 32'b10);
      chk("R5 race loser woken", 32'(wake_evt), 32'b0100);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R10 watchdog expired: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      clr();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_mismatch();
      t_steal();
      t_self();
      t_prio();
      t_release();
      clr(); cyc();
      summary();
      $finish;
   end
endmodule